// File: doc/BRIEF.md
# Overload Fault Timer with Double-Hiccup Restart

This block decides when a current-mode power controller must stop switching because of an overload or a shorted output, and how it comes back. Every cycle in which the peak current hits its ceiling, a fault timer advances. When the ceiling is no longer reached, the timer clears. The timer limit depends on the feedback level. A moderate overload gets the full duration. A feedback level above the short-circuit threshold gets one quarter of it. If the timer expires, the gate-drive enable is removed.

After a fault the supply rail is left to collapse. The block watches two comparator bits from the supply monitor: one says the rail is above the turn-on level, the other says it is below the turn-off level. The first recharge of the rail to the turn-on level is deliberately skipped. Drive resumes only on the next rise, so the average power in a persistent fault is halved. Each restart issues a one-cycle soft-start request. When the latched variant is selected, expiry leads to a permanent off state that only reset clears.

The states are RUN, FAULT_OFF, HICCUP_SKIP, HICCUP_WAIT and LATCHED, with these transitions:
- RUN→FAULT_OFF on expiry.
- RUN→LATCHED on expiry in latched mode.
- FAULT_OFF→HICCUP_SKIP when the rail drops below turn-off.
- HICCUP_SKIP→HICCUP_WAIT on the first turn-on indication.
- HICCUP_WAIT→RUN on the next rising turn-on indication.

Top module: `ovl_hiccup_ctrl`

## Requirements
- R1: During and right after reset, the state is RUN and reads 0, `drv_en_o` is 1 and `ss_req_o` is 0. A reset from any state, LATCHED included, returns to RUN. The `state_o` codes are RUN=0, FAULT_OFF=1, HICCUP_SKIP=2, HICCUP_WAIT=3 and LATCHED=4.
- R2: With `pk_lim_i` held at 1 and `fb_code_i` at or below `SC_CODE`, the timer expires after `TMR_FULL` ticks of `TICK_DIV` clocks each.
  - The state stays RUN for `TMR_FULL*TICK_DIV` clock edges.
  - It becomes FAULT_OFF on the next edge.
- R3: With `fb_code_i` strictly above `SC_CODE`, the limit is `TMR_FULL/4` ticks. The value `SC_CODE` itself still selects the full limit.
- R4: A single clock with `pk_lim_i` at 0 clears both the timer and the tick prescaler, and no expiry occurs in that clock.
- R5: When the feedback range changes while the timer runs, the elapsed count is compared against the limit of the new range. If the count is already at or past the quarter limit when the range turns short-circuit, the state leaves RUN on the next edge.
- R6: FAULT_OFF holds until `vcc_off_i` is 1, then moves to HICCUP_SKIP. Drive stays off.
- R7: In HICCUP_SKIP, the first `vcc_on_i`=1 moves to HICCUP_WAIT with no drive and no soft-start request.
- R8: In HICCUP_WAIT, a rising edge of `vcc_on_i`, i.e. 0 in one clock and 1 in the next, returns to RUN. `ss_req_o` is 1 for exactly the first RUN clock.
- R9: With `latch_mode_i` at 1, expiry enters LATCHED. LATCHED ignores `vcc_on_i`, `vcc_off_i` and `pk_lim_i` until reset.
- R10: `drv_en_o` is 1 only in RUN.
- R11: The timer is cleared outside RUN, so each restart starts from zero elapsed time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pk_lim_i | input | 1 | Peak current reached its maximum limit this cycle |
| fb_code_i | input | FB_W | Digitised feedback level |
| vcc_on_i | input | 1 | Supply above turn-on threshold |
| vcc_off_i | input | 1 | Supply below turn-off threshold |
| latch_mode_i | input | 1 | 1 selects permanent shutdown on expiry |
| drv_en_o | output | 1 | Gate-drive enable |
| ss_req_o | output | 1 | One-cycle soft-start request on restart |
| state_o | output | 3 | Current state code |

## Verification
Two situations are hardest to reach from the ports.

The first is the change of feedback range while the timer is counting. Hitting it takes the peak-limit flag held long enough that the elapsed count passes the quarter limit without reaching the full one, and only then a feedback code above the threshold. The stimulus table builds this with 40 clocks of overload feedback followed by one short-circuit clock.

The second is the double hiccup, which needs the supply flags walked through a complete fall, a first rise that must be skipped, another fall and a second rise. The table sequences those supply levels explicitly and checks that drive stays off through the first rise.

Boundary feedback codes on both sides of the threshold are applied after fresh resets.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    typedef enum logic [2:0] {
        ST_RUN         = 3'd0,
        ST_FAULT_OFF   = 3'd1,
        ST_HICCUP_SKIP = 3'd2,
        ST_HICCUP_WAIT = 3'd3,
        ST_LATCHED     = 3'd4
    } ovl_state_e;
endpackage

// File: rtl/ovl_tick_gen.sv
module ovl_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int DW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

    logic [DW-1:0] div_q;

    // prescaler restarts whenever counting is not enabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (!en_i || div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign tick_o = en_i && (div_q == LAST);
endmodule

// File: rtl/ovl_fault_timer.sv
module ovl_fault_timer #(
    parameter int TMR_FULL = 32,
    parameter int FB_W     = 8,
    parameter int SC_CODE  = 200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            tick_i,
    input  logic [FB_W-1:0] fb_i,
    output logic            expire_o
);
    localparam int TMR_QTR = TMR_FULL / 4;
    localparam int CW      = $clog2(TMR_FULL + 1);
    localparam logic [CW-1:0] LIM_FULL = CW'(TMR_FULL);
    localparam logic [CW-1:0] LIM_QTR  = CW'(TMR_QTR);

    logic [CW-1:0] elapsed_q;
    logic          short_rng;
    logic [CW-1:0] limit;

    assign short_rng = (fb_i > FB_W'(SC_CODE));
    assign limit     = short_rng ? LIM_QTR : LIM_FULL;

    // elapsed ticks, cleared when the peak limit is not hit or drive is off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            elapsed_q <= '0;
        else if (!en_i)
            elapsed_q <= '0;
        else if (tick_i && elapsed_q != LIM_FULL)
            elapsed_q <= elapsed_q + 1'b1;
    end

    // the elapsed count is compared against the limit of the present range
    assign expire_o = en_i && (elapsed_q >= limit);
endmodule

// File: rtl/ovl_hiccup_fsm.sv
module ovl_hiccup_fsm
    import ovl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire_i,
    input  logic       latch_mode_i,
    input  logic       vcc_on_i,
    input  logic       vcc_off_i,
    output logic [2:0] state_o,
    output logic       drv_en_o,
    output logic       ss_req_o,
    output logic       run_o
);
    ovl_state_e state_q, state_d;
    logic       on_q;
    logic       restart_q;
    logic       on_rise;

    assign on_rise = vcc_on_i && !on_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (expire_i)
                    state_d = latch_mode_i ? ST_LATCHED : ST_FAULT_OFF;
            end
            ST_FAULT_OFF: begin
                if (vcc_off_i)
                    state_d = ST_HICCUP_SKIP;
            end
            ST_HICCUP_SKIP: begin
                if (vcc_on_i)
                    state_d = ST_HICCUP_WAIT;
            end
            ST_HICCUP_WAIT: begin
                if (on_rise)
                    state_d = ST_RUN;
            end
            ST_LATCHED: state_d = ST_LATCHED;
            default:    state_d = ST_LATCHED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            on_q      <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            on_q      <= vcc_on_i;
            restart_q <= (state_q == ST_HICCUP_WAIT) && (state_d == ST_RUN);
        end
    end

    always_comb begin
        state_o  = state_q;
        run_o    = (state_q == ST_RUN);
        drv_en_o = (state_q == ST_RUN);
        ss_req_o = restart_q;
    end
endmodule

// File: rtl/ovl_hiccup_ctrl.sv
module ovl_hiccup_ctrl #(
    parameter int FB_W     = 8,
    parameter int SC_CODE  = 200,
    parameter int TICK_DIV = 4,
    parameter int TMR_FULL = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pk_lim_i,
    input  logic [FB_W-1:0] fb_code_i,
    input  logic            vcc_on_i,
    input  logic            vcc_off_i,
    input  logic            latch_mode_i,
    output logic            drv_en_o,
    output logic            ss_req_o,
    output logic [2:0]      state_o
);
    logic run;
    logic cnt_en;
    logic tick;
    logic expire;

    assign cnt_en = run && pk_lim_i;

    ovl_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (cnt_en),
        .tick_o (tick)
    );

    ovl_fault_timer #(
        .TMR_FULL (TMR_FULL),
        .FB_W     (FB_W),
        .SC_CODE  (SC_CODE)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (cnt_en),
        .tick_i   (tick),
        .fb_i     (fb_code_i),
        .expire_o (expire)
    );

    ovl_hiccup_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .expire_i     (expire),
        .latch_mode_i (latch_mode_i),
        .vcc_on_i     (vcc_on_i),
        .vcc_off_i    (vcc_off_i),
        .state_o      (state_o),
        .drv_en_o     (drv_en_o),
        .ss_req_o     (ss_req_o),
        .run_o        (run)
    );
endmodule

// File: rtl/ovl_hiccup_ctrl_chk.sv
module ovl_hiccup_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pk_lim_i,
    input logic       vcc_on_i,
    input logic       vcc_off_i,
    input logic       drv_en_o,
    input logic       ss_req_o,
    input logic [2:0] state_o
);
    // R8
    ss_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_req_o |=> !ss_req_o);

    // R8
    drv_rise_has_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en_o) |-> ss_req_o);

    // R9
    latched_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |=> (state_o == 3'd4));

    // R6
    fault_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && !vcc_off_i) |=> (state_o == 3'd1));

    // R4
    no_expiry_without_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && !pk_lim_i) |=> (state_o == 3'd0));

    // R7
    skip_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && !vcc_on_i) |=> (state_o == 3'd2 && !drv_en_o));
endmodule

bind ovl_hiccup_ctrl ovl_hiccup_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pk_lim_i  (pk_lim_i),
    .vcc_on_i  (vcc_on_i),
    .vcc_off_i (vcc_off_i),
    .drv_en_o  (drv_en_o),
    .ss_req_o  (ss_req_o),
    .state_o   (state_o)
);

// File: tb/ovl_hiccup_ctrl_bench.sv
module ovl_hiccup_ctrl_bench;
    localparam int CLK_NS = 20;

    typedef struct packed {
        logic        pk;
        logic [7:0]  fb;
        logic        on;
        logic        off;
        logic        lat;
        logic [15:0] cyc;
        logic        drv;
        logic [2:0]  st;
        logic        ss;
        logic [3:0]  req;
    } row_t;

    localparam int NROWS = 37;
    localparam row_t ROWS [NROWS] = '{
        // R2 full timer: 128 edges still RUN, next edge FAULT_OFF
        '{1'b1, 8'd100, 1'b1, 1'b0, 1'b0, 16'd128, 1'b1, 3'd0, 1'b0, 4'd2},
        '{1'b1, 8'd100, 1'b1, 1'b0, 1'b0, 16'd1,   1'b0, 3'd1, 1'b0, 4'd2},
        // R6 FAULT_OFF until supply drops
        '{1'b0, 8'd100, 1'b1, 1'b0, 1'b0, 16'd5,   1'b0, 3'd1, 1'b0, 4'd6},
        '{1'b0, 8'd100, 1'b0, 1'b1, 1'b0, 16'd1,   1'b0, 3'd2, 1'b0, 4'd6},
        // R7 first rise skipped
        '{1'b0, 8'd100, 1'b0, 1'b0, 1'b0, 16'd3,   1'b0, 3'd2, 1'b0, 4'd7},
        '{1'b0, 8'd100, 1'b1, 1'b0, 1'b0, 16'd1,   1'b0, 3'd3, 1'b0, 4'd7},
        '{1'b0, 8'd100, 1'b1, 1'b0, 1'b0, 16'd4,   1'b0, 3'd3, 1'b0, 4'd7},
        '{1'b0, 8'd100, 1'b0, 1'b1, 1'b0, 16'd2,   1'b0, 3'd3, 1'b0, 4'd7},
        // R8 second rise restarts with one soft-start pulse
        '{1'b0, 8'd100, 1'b1, 1'b0, 1'b0, 16'd1,   1'b1, 3'd0, 1'b1, 4'd8},
        '{1'b0, 8'd100, 1'b1, 1'b0, 1'b0, 16'd1,   1'b1, 3'd0, 1'b0, 4'd8},
        // R3 short circuit: quarter timer
        '{1'b1, 8'd250, 1'b1, 1'b0, 1'b0, 16'd32,  1'b1, 3'd0, 1'b0, 4'd3},
        '{1'b1, 8'd250, 1'b1, 1'b0, 1'b0, 16'd1,   1'b0, 3'd1, 1'b0, 4'd3},
        // restart
        '{1'b0, 8'd250, 1'b0, 1'b1, 1'b0, 16'd1,   1'b0, 3'd2, 1'b0, 4'd6},
        '{1'b0, 8'd250, 1'b1, 1'b0, 1'b0, 16'd1,   1'b0, 3'd3, 1'b0, 4'd7},
        '{1'b0, 8'd250, 1'b0, 1'b0, 1'b0, 16'd1,   1'b0, 3'd3, 1'b0, 4'd7},
        '{1'b0, 8'd250, 1'b1, 1'b0, 1'b0, 16'd1,   1'b1, 3'd0, 1'b1, 4'd8},
        // R11 stale count would expire at once
        '{1'b1, 8'd250, 1'b1, 1'b0, 1'b0, 16'd20,  1'b1, 3'd0, 1'b0, 4'd11},
        // R4 one idle clock clears timer and prescaler
        '{1'b0, 8'd250, 1'b1, 1'b0, 1'b0, 16'd1,   1'b1, 3'd0, 1'b0, 4'd4},
        '{1'b1, 8'd250, 1'b1, 1'b0, 1'b0, 16'd30,  1'b1, 3'd0, 1'b0, 4'd4},
        '{1'b1, 8'd250, 1'b1, 1'b0, 1'b0, 16'd2,   1'b1, 3'd0, 1'b0, 4'd4},
        '{1'b1, 8'd250, 1'b1, 1'b0, 1'b0, 16'd1,   1'b0, 3'd1, 1'b0, 4'd4},
        // restart
        '{1'b0, 8'd100, 1'b0, 1'b1, 1'b0, 16'd1,   1'b0, 3'd2, 1'b0, 4'd6},
        '{1'b0, 8'd100, 1'b1, 1'b0, 1'b0, 16'd1,   1'b0, 3'd3, 1'b0, 4'd7},
        '{1'b0, 8'd100, 1'b0, 1'b0, 1'b0, 16'd1,   1'b0, 3'd3, 1'b0, 4'd7},
        '{1'b0, 8'd100, 1'b1, 1'b0, 1'b0, 16'd1,   1'b1, 3'd0, 1'b1, 4'd8},
        // R5 range switch after 10 ticks
        '{1'b1, 8'd100, 1'b1, 1'b0, 1'b0, 16'd40,  1'b1, 3'd0, 1'b0, 4'd5},
        '{1'b1, 8'd250, 1'b1, 1'b0, 1'b0, 16'd1,   1'b0, 3'd1, 1'b0, 4'd5},
        // restart
        '{1'b0, 8'd100, 1'b0, 1'b1, 1'b0, 16'd1,   1'b0, 3'd2, 1'b0, 4'd6},
        '{1'b0, 8'd100, 1'b1, 1'b0, 1'b0, 16'd1,   1'b0, 3'd3, 1'b0, 4'd7},
        '{1'b0, 8'd100, 1'b0, 1'b0, 1'b0, 16'd1,   1'b0, 3'd3, 1'b0, 4'd7},
        '{1'b0, 8'd100, 1'b1, 1'b0, 1'b0, 16'd1,   1'b1, 3'd0, 1'b1, 4'd8},
        // R9 latched variant
        '{1'b1, 8'd100, 1'b1, 1'b0, 1'b1, 16'd128, 1'b1, 3'd0, 1'b0, 4'd9},
        '{1'b1, 8'd100, 1'b1, 1'b0, 1'b1, 16'd1,   1'b0, 3'd4, 1'b0, 4'd9},
        '{1'b0, 8'd100, 1'b0, 1'b1, 1'b1, 16'd5,   1'b0, 3'd4, 1'b0, 4'd9},
        '{1'b0, 8'd100, 1'b1, 1'b0, 1'b1, 16'd5,   1'b0, 3'd4, 1'b0, 4'd9},
        '{1'b0, 8'd100, 1'b0, 1'b0, 1'b1, 16'd3,   1'b0, 3'd4, 1'b0, 4'd9},
        '{1'b0, 8'd100, 1'b1, 1'b0, 1'b1, 16'd3,   1'b0, 3'd4, 1'b0, 4'd9}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pk_lim = 1'b0;
    logic [7:0] fb_code = 8'd0;
    logic       vcc_on = 1'b1;
    logic       vcc_off = 1'b0;
    logic       latch_mode = 1'b0;
    logic       drv_en;
    logic       ss_req;
    logic [2:0] state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    ovl_hiccup_ctrl u_ovl_hiccup_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pk_lim_i     (pk_lim),
        .fb_code_i    (fb_code),
        .vcc_on_i     (vcc_on),
        .vcc_off_i    (vcc_off),
        .latch_mode_i (latch_mode),
        .drv_en_o     (drv_en),
        .ss_req_o     (ss_req),
        .state_o      (state)
    );

    task automatic check(input logic e_drv, input logic [2:0] e_st,
                         input logic e_ss, input string req);
        checks++;
        if (drv_en !== e_drv || state !== e_st || ss_req !== e_ss) begin
            errors++;
            $display("FAIL %s: drv=%0b st=%0d ss=%0b expected drv=%0b st=%0d ss=%0b",
                     req, drv_en, state, ss_req, e_drv, e_st, e_ss);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pk_lim = 1'b0;
        latch_mode = 1'b0;
        vcc_on = 1'b1;
        vcc_off = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1'b1, 3'd0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b1, 3'd0, 1'b0, "R1 after reset");

        for (int i = 0; i < NROWS; i++) begin
            pk_lim     = ROWS[i].pk;
            fb_code    = ROWS[i].fb;
            vcc_on     = ROWS[i].on;
            vcc_off    = ROWS[i].off;
            latch_mode = ROWS[i].lat;
            run_cycles(int'(ROWS[i].cyc));
            check(ROWS[i].drv, ROWS[i].st, ROWS[i].ss,
                  $sformatf("R%0d row %0d", ROWS[i].req, i));
        end

        // R1 reset leaves LATCHED; R10 drive back on in RUN only
        do_reset();
        check(1'b1, 3'd0, 1'b0, "R1 reset from latched");

        // R3 boundary: code equal to threshold keeps full timer
        pk_lim = 1'b1;
        fb_code = 8'd200;
        run_cycles(33);
        check(1'b1, 3'd0, 1'b0, "R3 code at threshold");
        run_cycles(96);
        check(1'b0, 3'd1, 1'b0, "R2 expiry at threshold code");

        // R3 boundary: one above threshold uses quarter timer
        do_reset();
        pk_lim = 1'b1;
        fb_code = 8'd201;
        run_cycles(32);
        check(1'b1, 3'd0, 1'b0, "R3 just above threshold before expiry");
        run_cycles(1);
        check(1'b0, 3'd1, 1'b0, "R3 just above threshold expiry");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule